// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block governs thread selection for a pipeline that holds several hardware threads but issues from only one of them at a time. The chosen thread keeps issuing until it reports an expensive stall, such as a miss in the second-level cache. The controller then asks the pipeline to empty itself and waits until the pipeline reports that it is empty. It then picks another thread that is ready to run and opens a fixed refill window. During that window the new thread's instructions enter the pipeline but cannot yet complete. When the window closes, normal issue resumes.

Readiness is kept for each thread. An expensive stall marks the thread that reports it as not ready, and a miss-return event for that thread marks it ready again. Each thread also owns a fetch address register. The address of the stalled instruction is saved when a switch is triggered, so a thread that is switched back in fetches again from the point where it stopped. Short stalls never reach this block; the stall input carries only the costly ones.

The pipeline and the caches lie outside the block. The controller only drives the active thread number, the drain request, the fetch enable, a refill indication and the fetch address of the active thread.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, thread 0 is active and every thread is ready. `fetchEn` is 1, `flushReq` and `refillBusy` are 0, and thread t holds the fetch address PC_BASE + t*PC_STRIDE (default t*4096).
- R2: A costly stall that is sampled while issuing (fetchEn=1, refillBusy=0) and whose `stallThread` equals `activeThread` starts a switch. In the next cycle `flushReq`=1 and `fetchEn`=0.
- R3: `flushReq` stays 1 until `pipeEmpty` is sampled high. In the following cycle both `flushReq` and `fetchEn` are 0; this is the selection phase.
- R4: In the selection phase the controller picks the lowest-numbered ready thread other than the thread just switched out. If no thread qualifies, it stays in selection with `fetchEn`=0 and `flushReq`=0.
- R5: Once a thread is picked, a refill window of exactly REFILL_CYCLES cycles follows (default 5), with `refillBusy`=1 and `fetchEn`=1. Normal issue then resumes with `refillBusy`=0.
- R6: A costly stall sampled while draining, selecting or refilling starts no switch. It, and any other costly stall, still marks the reporting thread not ready. If a stall and a miss return name the same thread in the same cycle, the thread ends up not ready.
- R7: A miss return sampled for thread t (`returnValid`=1, `returnThread`=t) marks thread t ready.
- R8: `fetchPc` is the address register of the active thread. It grows by INSTR_BYTES (default 4) in each cycle with `fetchEn`=1 and `fetchTake`=1. A switch-triggering stall instead loads `stallPc` into that register, so the thread resumes fetching at `stallPc` when it is next picked.
- R9: `activeThread` changes only on the cycle where a pick is made, which is the first cycle of the refill window. Thread numbers are plain binary indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stallValid | input | 1 | Costly stall reported this cycle |
| stallThread | input | TW | Thread number of the stall report |
| stallPc | input | PC_WIDTH | Address of the instruction that missed |
| returnValid | input | 1 | Outstanding miss returned this cycle |
| returnThread | input | TW | Thread number of the miss return |
| pipeEmpty | input | 1 | Pipeline holds no in-flight instructions |
| fetchTake | input | 1 | Fetch consumed one instruction at fetchPc |
| activeThread | output | TW | Thread currently owning the pipeline |
| flushReq | output | 1 | Request to drain or freeze the pipeline |
| fetchEn | output | 1 | Fetch permitted for the active thread |
| refillBusy | output | 1 | Refill window open; new thread's work cannot complete |
| fetchPc | output | PC_WIDTH | Fetch address of the active thread |

## Verification
The assertions assume that thread numbers on `stallThread` and `returnThread` lie inside the thread count, and that `pipeEmpty` is meaningful only while a drain is requested. They also assume that a fetch step and a stall sampled in the same cycle resolve in favour of the stall. The random stimulus draws thread numbers modulo the thread count and leans stall reports towards the active thread so that switches happen often. It keeps stalls, returns and empty indications independent, which reaches the stall-during-drain and no-candidate cases without leaving those assumptions. Directed sequences force the empty-selection wait, the exclusion of the outgoing thread and the same-cycle stall and return.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_SELECT = 2'd2,
    ST_REFILL = 2'd3
  } swState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic saveMissPc;  // switch triggered: park stall address for active thread
    logic advancePc;   // fetch consumed an instruction of active thread
    logic takePick;    // commit the selected thread as active
  } swStrobe_t;

endpackage

// File: rtl/cgmt_pick.sv
module cgmt_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TW = 2
) (
  input  logic [NUM_THREADS-1:0] readyVec,
  input  logic [TW-1:0]          excludeId,
  output logic                   pickValid,
  output logic [TW-1:0]          pickId
);

  logic [NUM_THREADS-1:0] candVec;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gCand
    assign candVec[g] = readyVec[g] && (excludeId != TW'(g));
  end

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    pickValid = 1'b0;
    pickId    = '0;
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      if (candVec[i]) begin
        pickValid = 1'b1;
        pickId    = TW'(i);
      end
    end
  end

endmodule

// File: rtl/cgmt_ctrl.sv
module cgmt_ctrl
  import cgmt_pkg::*;
#(
  parameter int REFILL_CYCLES = 5,
  localparam int CW = $clog2(REFILL_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      stallValid,
  input  logic      stallHitsActive,
  input  logic      pipeEmpty,
  input  logic      pickValid,
  input  logic      fetchTake,
  output swStrobe_t strobe,
  output logic      fetchEn,
  output logic      flushReq,
  output logic      refillBusy
);

  swState_t stateQ;
  logic [CW-1:0] refillCnt;
  logic trigger;

  assign trigger = (stateQ == ST_RUN) && stallValid && stallHitsActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_RUN;
      refillCnt <= '0;
    end else begin
      unique case (stateQ)
        ST_RUN: begin
          if (trigger) stateQ <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (pipeEmpty) stateQ <= ST_SELECT;
        end
        ST_SELECT: begin
          if (pickValid) begin
            stateQ    <= ST_REFILL;
            refillCnt <= CW'(REFILL_CYCLES - 1);
          end
        end
        ST_REFILL: begin
          if (refillCnt == '0) stateQ <= ST_RUN;
          else                 refillCnt <= refillCnt - 1'b1;
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  assign fetchEn    = (stateQ == ST_RUN) || (stateQ == ST_REFILL);
  assign flushReq   = (stateQ == ST_DRAIN);
  assign refillBusy = (stateQ == ST_REFILL);

  always_comb begin
    strobe.saveMissPc = trigger;
    strobe.advancePc  = fetchEn && fetchTake && !trigger;
    strobe.takePick   = (stateQ == ST_SELECT) && pickValid;
  end

endmodule

// File: rtl/cgmt_dpath.sv
module cgmt_dpath
  import cgmt_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TW = 2,
  parameter int PC_WIDTH = 32,
  parameter int INSTR_BYTES = 4,
  parameter int unsigned PC_BASE = 0,
  parameter int unsigned PC_STRIDE = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  swStrobe_t           strobe,
  input  logic                stallValid,
  input  logic [TW-1:0]       stallThread,
  input  logic [PC_WIDTH-1:0] stallPc,
  input  logic                returnValid,
  input  logic [TW-1:0]       returnThread,
  output logic [TW-1:0]       activeThread,
  output logic [PC_WIDTH-1:0] fetchPc,
  output logic                stallHitsActive,
  output logic                pickValid
);

  logic [NUM_THREADS-1:0] readyQ;
  logic [PC_WIDTH-1:0]    pcQ [NUM_THREADS];
  logic [TW-1:0]          activeQ;
  logic [TW-1:0]          pickId;

  // readiness: stall clears, return sets, stall wins a tie
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= '1;
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (stallValid && (stallThread == TW'(i)))
          readyQ[i] <= 1'b0;
        else if (returnValid && (returnThread == TW'(i)))
          readyQ[i] <= 1'b1;
      end
    end
  end

  // per-thread fetch address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_THREADS; i++)
        pcQ[i] <= PC_WIDTH'(PC_BASE + PC_STRIDE * i);
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (activeQ == TW'(i)) begin
          if (strobe.saveMissPc)
            pcQ[i] <= stallPc;
          else if (strobe.advancePc)
            pcQ[i] <= pcQ[i] + PC_WIDTH'(INSTR_BYTES);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                activeQ <= '0;
    else if (strobe.takePick) activeQ <= pickId;
  end

  cgmt_pick #(
    .NUM_THREADS(NUM_THREADS),
    .TW         (TW)
  ) uPick (
    .readyVec (readyQ),
    .excludeId(activeQ),
    .pickValid(pickValid),
    .pickId   (pickId)
  );

  assign activeThread    = activeQ;
  assign fetchPc         = pcQ[activeQ];
  assign stallHitsActive = (stallThread == activeQ);

endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
  import cgmt_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int REFILL_CYCLES = 5,
  parameter int PC_WIDTH = 32,
  parameter int INSTR_BYTES = 4,
  parameter int unsigned PC_BASE = 0,
  parameter int unsigned PC_STRIDE = 4096,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stallValid,
  input  logic [TW-1:0]       stallThread,
  input  logic [PC_WIDTH-1:0] stallPc,
  input  logic                returnValid,
  input  logic [TW-1:0]       returnThread,
  input  logic                pipeEmpty,
  input  logic                fetchTake,
  output logic [TW-1:0]       activeThread,
  output logic                flushReq,
  output logic                fetchEn,
  output logic                refillBusy,
  output logic [PC_WIDTH-1:0] fetchPc
);

  swStrobe_t strobe;
  logic stallHitsActive;
  logic pickValid;

  cgmt_ctrl #(
    .REFILL_CYCLES(REFILL_CYCLES)
  ) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .stallValid     (stallValid),
    .stallHitsActive(stallHitsActive),
    .pipeEmpty      (pipeEmpty),
    .pickValid      (pickValid),
    .fetchTake      (fetchTake),
    .strobe         (strobe),
    .fetchEn        (fetchEn),
    .flushReq       (flushReq),
    .refillBusy     (refillBusy)
  );

  cgmt_dpath #(
    .NUM_THREADS(NUM_THREADS),
    .TW         (TW),
    .PC_WIDTH   (PC_WIDTH),
    .INSTR_BYTES(INSTR_BYTES),
    .PC_BASE    (PC_BASE),
    .PC_STRIDE  (PC_STRIDE)
  ) uDpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .stallValid     (stallValid),
    .stallThread    (stallThread),
    .stallPc        (stallPc),
    .returnValid    (returnValid),
    .returnThread   (returnThread),
    .activeThread   (activeThread),
    .fetchPc        (fetchPc),
    .stallHitsActive(stallHitsActive),
    .pickValid      (pickValid)
  );

endmodule

// File: rtl/cgmt_checker.sv
module cgmt_checker #(
  parameter int NUM_THREADS = 4,
  parameter int REFILL_CYCLES = 5,
  parameter int PC_WIDTH = 32,
  parameter int INSTR_BYTES = 4,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                stallValid,
  input logic [TW-1:0]       stallThread,
  input logic                pipeEmpty,
  input logic                fetchTake,
  input logic [TW-1:0]       activeThread,
  input logic                flushReq,
  input logic                fetchEn,
  input logic                refillBusy,
  input logic [PC_WIDTH-1:0] fetchPc
);

  int refillRun;

  always_ff @(posedge clk) begin
    if (!rstN)           refillRun <= 0;
    else if (refillBusy) refillRun <= refillRun + 1;
    else                 refillRun <= 0;
  end

  AST_TRIGGER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn && !refillBusy && stallValid && (stallThread == activeThread)) |=> (flushReq && !fetchEn)); // R2

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !pipeEmpty) |=> flushReq); // R3

  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && pipeEmpty) |=> (!flushReq && !fetchEn)); // R3

  AST_SELECT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchEn && !flushReq) |=> !flushReq); // R4

  AST_REFILL_MAX: assert property (@(posedge clk) disable iff (!rstN)
    refillBusy |-> (refillRun < REFILL_CYCLES)); // R5

  AST_REFILL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refillBusy) |-> (refillRun == REFILL_CYCLES)); // R5

  AST_REFILL_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    refillBusy |=> !flushReq); // R6

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn && fetchTake && !stallValid) |=> (fetchPc == $past(fetchPc) + PC_WIDTH'(INSTR_BYTES))); // R8

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn || flushReq) |=> $stable(activeThread)); // R9

  AST_SWITCH_OPENS_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeThread) |-> refillBusy); // R9

endmodule

bind cgmt_switch_ctrl cgmt_checker #(
  .NUM_THREADS  (NUM_THREADS),
  .REFILL_CYCLES(REFILL_CYCLES),
  .PC_WIDTH     (PC_WIDTH),
  .INSTR_BYTES  (INSTR_BYTES)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .stallValid  (stallValid),
  .stallThread (stallThread),
  .pipeEmpty   (pipeEmpty),
  .fetchTake   (fetchTake),
  .activeThread(activeThread),
  .flushReq    (flushReq),
  .fetchEn     (fetchEn),
  .refillBusy  (refillBusy),
  .fetchPc     (fetchPc)
);

// File: tb/tb_cgmt_switch_ctrl.sv
module tb_cgmt_switch_ctrl;

  localparam int NT = 4;
  localparam int RC = 5;
  localparam int STRIDE = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stallValid = 1'b0;
  logic [1:0]  stallThread = '0;
  logic [31:0] stallPc = '0;
  logic        returnValid = 1'b0;
  logic [1:0]  returnThread = '0;
  logic        pipeEmpty = 1'b0;
  logic        fetchTake = 1'b0;
  logic [1:0]  activeThread;
  logic        flushReq;
  logic        fetchEn;
  logic        refillBusy;
  logic [31:0] fetchPc;

  int checks = 0;
  int errors = 0;

  // bench model: 0 issue, 1 drain, 2 select, 3 refill
  int          mState;
  int          mActive;
  int          mCnt;
  bit          mReady [NT];
  logic [31:0] mPc [NT];

  always #2 clk = ~clk;

  cgmt_switch_ctrl #(
    .NUM_THREADS  (NT),
    .REFILL_CYCLES(RC)
  ) dut (
    .clk         (clk),
    .rstN        (rstN),
    .stallValid  (stallValid),
    .stallThread (stallThread),
    .stallPc     (stallPc),
    .returnValid (returnValid),
    .returnThread(returnThread),
    .pipeEmpty   (pipeEmpty),
    .fetchTake   (fetchTake),
    .activeThread(activeThread),
    .flushReq    (flushReq),
    .fetchEn     (fetchEn),
    .refillBusy  (refillBusy),
    .fetchPc     (fetchPc)
  );

  task automatic checkEq(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pickModel();
    int p = -1;
    for (int i = 0; i < NT; i++)
      if (p < 0 && mReady[i] && i != mActive) p = i;
    return p;
  endfunction

  task automatic modelReset();
    mState = 0; mActive = 0; mCnt = 0;
    for (int i = 0; i < NT; i++) begin
      mReady[i] = 1'b1;
      mPc[i] = 32'(i * STRIDE);
    end
  endtask

  task automatic modelTick(input bit sv, input int st, input logic [31:0] spc,
                           input bit rv, input int rt, input bit pe, input bit tk);
    bit fe;
    bit trig;
    int pk;
    fe   = (mState == 0) || (mState == 3);
    trig = (mState == 0) && sv && (st == mActive);
    pk   = pickModel();
    if (trig)          mPc[mActive] = spc;
    else if (fe && tk) mPc[mActive] = mPc[mActive] + 32'd4;
    case (mState)
      0: if (trig) mState = 1;
      1: if (pe) mState = 2;
      2: if (pk >= 0) begin mActive = pk; mState = 3; mCnt = RC - 1; end
      default: if (mCnt == 0) mState = 0; else mCnt = mCnt - 1;
    endcase
    if (rv) mReady[rt] = 1'b1;
    if (sv) mReady[st] = 1'b0;
  endtask

  task automatic compareAll();
    checkEq("R9/R4", "activeThread", activeThread, mActive);
    checkEq("R2/R3", "flushReq", flushReq, (mState == 1));
    checkEq("R5", "fetchEn", fetchEn, (mState == 0 || mState == 3));
    checkEq("R5", "refillBusy", refillBusy, (mState == 3));
    checkEq("R8", "fetchPc", fetchPc, mPc[mActive]);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit sv, input int st, input logic [31:0] spc,
                      input bit rv, input int rt, input bit pe, input bit tk);
    stallValid   = sv;
    stallThread  = 2'(st);
    stallPc      = spc;
    returnValid  = rv;
    returnThread = 2'(rt);
    pipeEmpty    = pe;
    fetchTake    = tk;
    @(posedge clk);
    modelTick(sv, st, spc, rv, rt, pe, tk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n, input bit pe);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, pe, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkEq("R1", "activeThread", activeThread, 0);
    checkEq("R1", "fetchEn", fetchEn, 1);
    checkEq("R1", "flushReq", flushReq, 0);
    checkEq("R1", "refillBusy", refillBusy, 0);
    checkEq("R1", "fetchPc", fetchPc, 0);

    idle(3, 0);
    checkEq("R8", "fetchPc after 3 fetches", fetchPc, 12);

    // R2: thread 0 misses at 0x40
    step(1, 0, 32'h40, 0, 0, 0, 1);
    checkEq("R2", "flushReq after trigger", flushReq, 1);
    // R6: thread 1 stall during drain does not retrigger but marks it not ready
    step(1, 1, 32'h1010, 0, 0, 0, 0);
    checkEq("R3", "drain held without empty", flushReq, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    checkEq("R3", "selection after empty", {flushReq, fetchEn}, 2'b00);
    step(0, 0, 0, 0, 0, 0, 0);
    checkEq("R4", "picked thread skips 0 and 1", activeThread, 2);
    checkEq("R5", "refill open", refillBusy, 1);
    // R6: active thread stalls inside refill: ignored for triggering
    step(1, 2, 32'h2000, 0, 0, 0, 1);
    for (int k = 0; k < RC - 2; k++) step(0, 0, 0, 0, 0, 0, 1);
    checkEq("R5", "refill last cycle", refillBusy, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    checkEq("R5", "refill closed after window", refillBusy, 0);
    checkEq("R6", "no drain from refill stall", flushReq, 0);

    // thread 3 marked not ready while not active, then thread 2 triggers
    step(1, 3, 32'h3000, 0, 0, 0, 1);
    step(1, 2, 32'h2080, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    idle(3, 0);
    checkEq("R4", "no candidate: fetch off", fetchEn, 0);
    checkEq("R4", "no candidate: stays on thread 2", activeThread, 2);
    step(0, 0, 0, 1, 2, 0, 0);   // outgoing thread returns: still excluded
    idle(2, 0);
    checkEq("R4", "outgoing thread not reselected", refillBusy, 0);
    step(0, 0, 0, 1, 0, 0, 0);   // R7 thread 0 returns
    step(0, 0, 0, 0, 0, 0, 0);
    checkEq("R7", "returned thread 0 picked", activeThread, 0);
    checkEq("R8", "thread 0 resumes at miss address", fetchPc, 32'h40);
    idle(RC, 0);

    // R6: stall and return for thread 1 in one cycle -> not ready
    step(1, 1, 32'h1000, 1, 1, 0, 0);
    step(0, 0, 0, 1, 3, 0, 0);
    step(1, 0, 32'h80, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    checkEq("R6", "stall beats return for thread 1", activeThread, 2);
    checkEq("R8", "thread 2 resumes at its miss", fetchPc, 32'h2080);
    idle(RC, 0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit sv;
      bit rv;
      bit pe;
      bit tk;
      int st;
      int rt;
      sv = ($urandom % 10) == 0;
      st = ($urandom % 2) ? mActive : int'($urandom % NT);
      rv = ($urandom % 5) == 0;
      rt = int'($urandom % NT);
      pe = ($urandom % 3) == 0;
      tk = $urandom % 2;
      step(sv, st, {$urandom, 2'b00} , rv, rt, pe, tk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule